// File: doc/BRIEF.md
# Fractional-Rate Clock-Enable Generator

This block derives two streams of single-cycle enable pulses from one fast system clock, without a PLL. Each stream comes from a phase accumulator that adds a fixed step every cycle. A pulse is produced whenever the accumulator wraps. The long-run pulse rate can therefore be any fraction of the system clock, not only an integer division of it. The steps are worked out at elaboration from frequency parameters, so the same code serves a 100 MHz clock or a 54 MHz clock.

The first stream is the operating enable for a programmable sound generator. Its default rate is 1.78 MHz from a 100 MHz clock. The block also has a host-access input. The first cycle of each host bus access forces one extra enable pulse into this stream, so the sound generator always gets a clock tick while the access is under way.

The second stream is the bit-clock enable for an audio serial shifter. A select input switches it between the rate for 48 kHz sampling (1.536 MHz) and the rate for 44.1 kHz sampling (1.4112 MHz). All downstream logic uses the system clock and treats these outputs as clock enables.

Top module: `fracstrobe_gen`

## Requirements
- R1: Every pulse produced by accumulator wrap is exactly one system-clock cycle wide. Two wrap pulses of the same channel never fall on adjacent cycles.
- R2: Over any long window, the number of pulses on `psg_en_o`, with no host accesses, is within one of window × PSG_HZ / CLK_HZ. The defaults are 1.78 MHz and 100 MHz.
- R3: With `rate_sel_i` = 0, the number of pulses on `bclk_en_o` over a long window is within one of window × 1.536 MHz / CLK_HZ.
- R4: With `rate_sel_i` = 1, the number of pulses on `bclk_en_o` over a long window is within one of window × 1.4112 MHz / CLK_HZ.
- R5: Each channel is a 32-bit accumulator that adds step = round(f_out × 2^32 / CLK_HZ) at every clock edge. Its output is high during the cycle that follows an edge at which that addition carried out of bit 31.
- R6: When `host_access_i` is sampled high at an edge after being low (or after reset), `psg_en_o` is high in the following cycle. An access held high for many cycles adds exactly one pulse.
- R7: If a forced host pulse and a wrap pulse fall in the same cycle, `psg_en_o` shows a single one-cycle pulse, and it is low in the next cycle.
- R8: A synchronous active-high `rst_i` clears both accumulators and the host edge detector, and both outputs are low in every cycle after an edge that samples reset high. A host access that is held high across reset release counts as a new access.
- R9: A change of `rate_sel_i` changes the step used at the very next edge. The accumulator keeps its value, so no two bit-clock pulses come closer together than floor(2^32 / step at 48 kHz) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rate_sel_i | input | 1 | Bit-clock rate: 0 = 48 kHz family, 1 = 44.1 kHz family |
| host_access_i | input | 1 | High while a host bus access to the sound generator is in progress |
| psg_en_o | output | 1 | Sound-generator clock enable, one cycle per pulse |
| bclk_en_o | output | 1 | Audio bit-clock enable, one cycle per pulse |

## Verification
The sound-generator accumulator wrap and the forced pulse from the start of a host access can land on the same cycle. The bench runs its own accumulator model built from the step formula. It waits until the model predicts a wrap on the coming edge and raises the host input for exactly that edge. It then expects one high cycle followed by a low cycle. Over a series of accesses with varied widths, it also expects the observed pulse total to equal the wraps plus the accesses minus the cycles where the two fell together.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int unsigned PHASE_W = 32;

    typedef logic [PHASE_W-1:0] phase_t;

    // registered outputs of the top level
    typedef struct packed {
        logic psg_en;
        logic bclk_en;
    } strobe_state_t;

    // rounded phase step for a target rate: round(f_out * 2^w / f_clk)
    function automatic longint unsigned step_for(input longint unsigned f_out,
                                                 input longint unsigned f_clk,
                                                 input int unsigned     w);
        longint unsigned num;
        num = (f_out << w) + (f_clk >> 1);
        return num / f_clk;
    endfunction

endpackage

// File: rtl/fsg_phase_acc.sv
module fsg_phase_acc #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ACC_W-1:0] step_i,
    output logic             wrap_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t     st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        sum    = {1'b0, st_q.acc} + {1'b0, step_i};
        st_d   = st_q;
        wrap_o = sum[ACC_W];
        if (rst_i) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // a step below half the range never wraps on two edges in a row
    assert_wrap_single_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> !wrap_o);

endmodule

// File: rtl/fsg_rise_det.sv
module fsg_rise_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic rise_o
);

    typedef struct packed {
        logic level;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = rst_i ? 1'b0 : level_i;
        rise_o     = level_i & ~st_q.level;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // one access start yields one detection cycle only
    assert_rise_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fracstrobe_gen.sv
module fracstrobe_gen #(
    parameter longint unsigned CLK_HZ    = 100_000_000,
    parameter longint unsigned PSG_HZ    = 1_780_000,
    parameter longint unsigned BCLK48_HZ = 1_536_000,
    parameter longint unsigned BCLK44_HZ = 1_411_200,
    parameter int unsigned     ACC_W     = fsg_pkg::PHASE_W
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rate_sel_i,
    input  logic host_access_i,
    output logic psg_en_o,
    output logic bclk_en_o
);

    import fsg_pkg::*;

    localparam int unsigned NUM_CH  = 2;
    localparam int unsigned CH_PSG  = 0;
    localparam int unsigned CH_BCLK = 1;

    localparam logic [ACC_W-1:0] STEP_PSG  = ACC_W'(step_for(PSG_HZ,    CLK_HZ, ACC_W));
    localparam logic [ACC_W-1:0] STEP_B48  = ACC_W'(step_for(BCLK48_HZ, CLK_HZ, ACC_W));
    localparam logic [ACC_W-1:0] STEP_B44  = ACC_W'(step_for(BCLK44_HZ, CLK_HZ, ACC_W));

    logic [ACC_W-1:0] ch_step [NUM_CH];
    logic [NUM_CH-1:0] ch_wrap;
    logic              host_rise;

    strobe_state_t st_d, st_q;

    assign ch_step[CH_PSG]  = STEP_PSG;
    assign ch_step[CH_BCLK] = rate_sel_i ? STEP_B44 : STEP_B48;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        fsg_phase_acc #(
            .ACC_W (ACC_W)
        ) u_acc (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .step_i (ch_step[ch]),
            .wrap_o (ch_wrap[ch])
        );
    end

    fsg_rise_det u_host (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (host_access_i),
        .rise_o  (host_rise)
    );

    always_comb begin
        st_d         = st_q;
        st_d.psg_en  = !rst_i && (ch_wrap[CH_PSG] || host_rise);
        st_d.bclk_en = !rst_i && ch_wrap[CH_BCLK];
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign psg_en_o  = st_q.psg_en;
    assign bclk_en_o = st_q.bclk_en;

    assert_quiet_in_reset_R8: assert property (@(posedge clk_i)
        rst_i |=> (!psg_en_o && !bclk_en_o));

    assert_host_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(host_access_i) |=> psg_en_o);

    assert_bclk_single_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        bclk_en_o |=> !bclk_en_o);

endmodule

// File: tb/sim_fracstrobe_gen.sv
module sim_fracstrobe_gen;

    localparam time CLK_PERIOD = 10ns;
    localparam longint unsigned F_CLK = 100_000_000;
    localparam longint unsigned F_PSG = 1_780_000;
    localparam longint unsigned F_B48 = 1_536_000;
    localparam longint unsigned F_B44 = 1_411_200;
    localparam logic [31:0] STEP_P   = 32'(((F_PSG << 32) + F_CLK / 2) / F_CLK);
    localparam logic [31:0] STEP_48  = 32'(((F_B48 << 32) + F_CLK / 2) / F_CLK);
    localparam logic [31:0] STEP_44  = 32'(((F_B44 << 32) + F_CLK / 2) / F_CLK);
    localparam longint      MIN_GAP  = longint'((64'd1 << 32) / {32'd0, STEP_48});
    localparam int          WINDOW   = 30000;
    localparam int          WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0;
    logic host = 1'b0;
    logic psg_en, bclk_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference model state
    logic [31:0] m_acc_p = '0;
    logic [31:0] m_acc_b = '0;
    logic        m_hq = 1'b0;
    logic        exp_p = 1'b0;
    logic        exp_b = 1'b0;
    longint      m_carry = 0, m_edge = 0, m_both = 0;
    longint      cnt_p = 0, cnt_b = 0, cyc = 0, mis = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fracstrobe_gen u0 (
        .clk_i         (clk),
        .rst_i         (rst),
        .rate_sel_i    (sel),
        .host_access_i (host),
        .psg_en_o      (psg_en),
        .bclk_en_o     (bclk_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, expv);
        end
    endtask

    // one clock: predict, step past the edge, compare away from it
    task automatic tick();
        logic [32:0] s;
        logic        e;
        if (rst) begin
            m_acc_p = '0; m_acc_b = '0; m_hq = 1'b0;
            exp_p = 1'b0; exp_b = 1'b0;
        end else begin
            s = {1'b0, m_acc_p} + {1'b0, STEP_P};
            m_acc_p = s[31:0];
            e = host & ~m_hq;
            exp_p = s[32] | e;
            if (s[32]) m_carry++;
            if (e) m_edge++;
            if (s[32] && e) m_both++;
            s = {1'b0, m_acc_b} + {1'b0, (sel ? STEP_44 : STEP_48)};
            m_acc_b = s[31:0];
            exp_b = s[32];
            m_hq = host;
        end
        @(posedge clk);
        #1;
        if (psg_en !== exp_p || bclk_en !== exp_b) mis++;
        if (psg_en) cnt_p++;
        if (bclk_en) cnt_b++;
        cyc++;
    endtask

    task automatic t_reset();
        int loud = 0;
        rst = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (psg_en !== 1'b0 || bclk_en !== 1'b0) loud++;
        end
        check(loud == 0, "R8", "outputs low under reset", real'(loud), 0.0);
        rst = 1'b0;
    endtask

    task automatic t_rate(input logic s);
        longint p0, b0, m0;
        real ip, ib;
        sel = s;
        p0 = cnt_p; b0 = cnt_b; m0 = mis;
        for (int i = 0; i < WINDOW; i++) tick();
        ip = real'(WINDOW) * real'(F_PSG) / real'(F_CLK);
        ib = real'(WINDOW) * real'(s ? F_B44 : F_B48) / real'(F_CLK);
        check((real'(cnt_p - p0) - ip) <= 1.001 && (ip - real'(cnt_p - p0)) <= 1.001,
              "R2", "sound enable count", real'(cnt_p - p0), ip);
        check((real'(cnt_b - b0) - ib) <= 1.001 && (ib - real'(cnt_b - b0)) <= 1.001,
              s ? "R4" : "R3", "bit-clock enable count", real'(cnt_b - b0), ib);
        check(mis == m0, "R5", "cycle-exact match to accumulator model",
              real'(mis - m0), 0.0);
    endtask

    task automatic t_host();
        longint p0, c0, bo0, m0;
        int late = 0;
        p0 = cnt_p; c0 = m_carry; bo0 = m_both; m0 = mis;
        for (int w = 1; w <= 20; w++) begin
            host = 1'b1;
            tick();
            if (psg_en !== 1'b1) late++;
            for (int k = 1; k < w; k++) tick();
            host = 1'b0;
            for (int k = 0; k < 37; k++) tick();
        end
        check(late == 0, "R6", "pulse after access start", real'(late), 0.0);
        check((cnt_p - p0) == (m_carry - c0) + 20 - (m_both - bo0), "R6",
              "one extra pulse per access", real'(cnt_p - p0),
              real'((m_carry - c0) + 20 - (m_both - bo0)));
        check(mis == m0, "R6", "host stream matches model", real'(mis - m0), 0.0);
    endtask

    task automatic t_coincide();
        logic [32:0] pr;
        longint bo0;
        int hi_bad = 0, lo_bad = 0;
        host = 1'b0;
        bo0 = m_both;
        for (int n = 0; n < 3; n++) begin
            while (1) begin
                pr = {1'b0, m_acc_p} + {1'b0, STEP_P};
                if (pr[32]) break;
                tick();
            end
            host = 1'b1;
            tick();
            if (psg_en !== 1'b1) hi_bad++;
            tick();
            if (psg_en !== 1'b0) lo_bad++;
            host = 1'b0;
            for (int k = 0; k < 5; k++) tick();
        end
        check((m_both - bo0) == 3, "R7", "coincidences provoked", real'(m_both - bo0), 3.0);
        check(hi_bad == 0, "R7", "merged pulse present", real'(hi_bad), 0.0);
        check(lo_bad == 0, "R7", "merged pulse one cycle wide", real'(lo_bad), 0.0);
    endtask

    task automatic t_sel_switch();
        longint last = -1, m0;
        int close = 0;
        m0 = mis;
        for (int i = 0; i < 2000; i++) begin
            if (i % 7 == 0) sel = ~sel;
            tick();
            if (bclk_en) begin
                if (last >= 0 && (cyc - last) < MIN_GAP) close++;
                last = cyc;
            end
        end
        check(close == 0, "R9", "no burst on rate change", real'(close), 0.0);
        check(mis == m0, "R9", "step switches on next edge", real'(mis - m0), 0.0);
        sel = 1'b0;
    endtask

    task automatic t_midreset();
        longint m0;
        int loud = 0;
        for (int i = 0; i < 100; i++) tick();
        host = 1'b1;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (psg_en !== 1'b0 || bclk_en !== 1'b0) loud++;
        end
        check(loud == 0, "R8", "mid-run reset silences outputs", real'(loud), 0.0);
        rst = 1'b0;
        m0 = mis;
        tick();
        check(psg_en === 1'b1, "R8", "held access seen after release",
              real'(psg_en), 1.0);
        for (int i = 0; i < 200; i++) tick();
        host = 1'b0;
        for (int i = 0; i < 50; i++) tick();
        check(mis == m0, "R8", "accumulators restart from zero", real'(mis - m0), 0.0);
    endtask

    initial begin
        #1;
        t_reset();
        t_rate(1'b0);
        t_rate(1'b1);
        sel = 1'b0;
        t_host();
        t_coincide();
        t_sel_switch();
        t_midreset();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", WATCHDOG, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule